// File: doc/BRIEF.md
# Hashed Page Table Address Generator

This block turns a 32-bit effective address into everything a page-table walker needs before it touches memory. The top four address bits pick one of sixteen segment registers. The block XORs that segment's virtual segment identifier with the page index to form a hash. It then produces the physical address of the primary page-table entry group, and of the secondary group built from the complemented hash. Both addresses are masked by the size field of a table-base register. The block also produces the word that a matching page-table entry must carry, a protection key bit derived from the privilege level, and a result code.

A request is presented for one cycle with its address, its access kind and the privilege flag. The results appear one cycle later, marked by a valid strobe. Segment registers and the table-base register are loaded through simple write ports.

Segments flagged as direct-store bypass hashing. Instruction fetches there are refused. Data accesses either pass the effective address straight through or raise a protection fault, depending on the key.

Top module: `hpt_addr_gen`

## Requirements
- R1: After reset, `outValid` is 0, all sixteen segment registers read as zero and the table-base register is zero. A read to address 0 then yields a primary group address of 0x00000000 and a secondary group address of 0x0000FFC0.
- R2: `outValid` is 1 in exactly the cycles that follow a cycle with `reqValid` high. The outputs it marks describe that request.
- R3: The segment register used is the one indexed by address bits 31:28. A write with `segWrEn` high stores `segWrData` into entry `segWrIdx`.
- R4: In each segment register, bit 30 is the supervisor key, bit 29 the user key, bit 28 no-execute, bit 31 the direct-store flag, and bits 23:0 the segment identifier. `keyBit` is 1 when (user key and `reqUser`) or (supervisor key and not `reqUser`).
- R5: For a hashed result, let the hash be ((segment id XOR address bits 27:12) shifted left 6) AND 0x01FFFFC0. Let the mask be (base bits 8:0 shifted left 16) OR 0xFFC0. Then `primAddr` = (base AND 0xFFFF0000) OR (hash AND mask).
- R6: `secAddr` uses the same formula, with the hash replaced by (NOT hash) AND 0x01FFFFC0.
- R7: `cmpWord` = (segment id shifted left 7) OR address bits 27:22, with bit 6 zero.
- R8: `faultCode` encodes 0 = hashed, 1 = direct pass-through, 2 = protection fault, 3 = direct-store error. `reqType` encodes 0 = read, 1 = write, 2 = fetch. A fetch in a non-direct segment with no-execute set gives code 2. Whenever the code is not 0, `primAddr`, `secAddr` and `cmpWord` are zero.
- R9: A fetch in a direct-store segment gives code 3.
- R10: A data access in a direct-store segment gives code 2 when it is a write and `keyBit` would be 1. Otherwise it gives code 1, with `directAddr` equal to the effective address. `directAddr` is zero for every code other than 1.
- R11: When a segment or base write falls in the same cycle as a request, the request uses the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segWrEn | input | 1 | Segment register write strobe |
| segWrIdx | input | 4 | Segment register index |
| segWrData | input | 32 | Segment register data |
| baseWrEn | input | 1 | Table-base register write strobe |
| baseWrData | input | 32 | Table-base register data |
| reqValid | input | 1 | Translation request strobe |
| reqAddr | input | 32 | Effective address |
| reqType | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| reqUser | input | 1 | 1 = problem (user) state |
| outValid | output | 1 | Result strobe, one cycle after request |
| primAddr | output | 32 | Primary group physical address |
| secAddr | output | 32 | Secondary group physical address |
| cmpWord | output | 32 | Entry compare word |
| keyBit | output | 1 | Protection key |
| faultCode | output | 2 | Result code |
| directAddr | output | 32 | Pass-through address for direct-store data |

## Verification
The properties assume that `reqType` never carries the unused value 3, and the stimulus draws the type only from read, write and fetch. They also assume that `reqAddr` and `reqType` held during a request cycle are the values the following output cycle refers back to. This holds because the bench changes inputs only away from the clock edge. Writes to the segment bank and the base register are mixed freely with requests, including in the same cycle, so the before-write ordering is exercised under random traffic as well as in directed cases.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } accType_e;

  typedef enum logic [1:0] {
    RES_HASH   = 2'd0,
    RES_DIRECT = 2'd1,
    RES_PROT   = 2'd2,
    RES_DSERR  = 2'd3
  } result_e;

  // Attribute bits of the selected segment, datapath to control
  typedef struct packed {
    logic direct;
    logic supKey;
    logic usrKey;
    logic noExec;
  } segAttr_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic genHash;
    logic passDirect;
  } dpCtrl_t;

endpackage

// File: rtl/hpt_dp.sv
module hpt_dp
  import hpt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_SEG    = 16,
  parameter int VSID_W     = 24,
  parameter int PAGE_SHIFT = 12,
  parameter int TAB_SHIFT  = 16,
  parameter int HASH_SHIFT = 6,
  parameter int MASK_BITS  = 9,
  parameter int API_W      = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       segWrEn,
  input  logic [$clog2(NUM_SEG)-1:0] segWrIdx,
  input  logic [ADDR_W-1:0]          segWrData,
  input  logic                       baseWrEn,
  input  logic [ADDR_W-1:0]          baseWrData,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  dpCtrl_t                    ctrl,
  output segAttr_t                   segAttr,
  output logic [ADDR_W-1:0]          primAddr,
  output logic [ADDR_W-1:0]          secAddr,
  output logic [ADDR_W-1:0]          cmpWord,
  output logic [ADDR_W-1:0]          directAddr
);

  localparam int SEG_IDX_W = $clog2(NUM_SEG);
  localparam int SEG_SHIFT = ADDR_W - SEG_IDX_W;
  localparam int PIDX_W    = SEG_SHIFT - PAGE_SHIFT;
  localparam logic [ADDR_W-1:0] HASH_TOP = ADDR_W'((64'd1 << (TAB_SHIFT + MASK_BITS)) - 64'd1);
  localparam logic [ADDR_W-1:0] HASH_LOW = ADDR_W'((64'd1 << HASH_SHIFT) - 64'd1);
  localparam logic [ADDR_W-1:0] TAB_LOW  = ADDR_W'((64'd1 << TAB_SHIFT) - 64'd1);
  localparam logic [ADDR_W-1:0] HASH_FIELD = HASH_TOP & ~HASH_LOW;
  localparam logic [ADDR_W-1:0] LOW_FIXED  = TAB_LOW & ~HASH_LOW;
  localparam logic [ADDR_W-1:0] BASE_HI    = ~TAB_LOW;

  logic [NUM_SEG-1:0][ADDR_W-1:0] segBank;
  logic [ADDR_W-1:0]              baseReg;

  // Segment register bank and table base
  always_ff @(posedge clk) begin
    if (!rstN) begin
      segBank <= '0;
      baseReg <= '0;
    end else begin
      for (int i = 0; i < NUM_SEG; i++) begin
        if (segWrEn && (segWrIdx == SEG_IDX_W'(i))) segBank[i] <= segWrData;
      end
      if (baseWrEn) baseReg <= baseWrData;
    end
  end

  logic [SEG_IDX_W-1:0] segIdx;
  logic [ADDR_W-1:0]    segSel;
  logic [VSID_W-1:0]    vsid;
  logic [PIDX_W-1:0]    pageIdx;
  logic [ADDR_W-1:0]    hashPri, hashSec, tabMask, groupPri, groupSec, cmpNext;

  always_comb begin
    segIdx  = reqAddr[ADDR_W-1 -: SEG_IDX_W];
    segSel  = segBank[segIdx];
    vsid    = segSel[VSID_W-1:0];
    pageIdx = reqAddr[SEG_SHIFT-1:PAGE_SHIFT];

    segAttr.direct = segSel[ADDR_W-1];
    segAttr.supKey = segSel[ADDR_W-2];
    segAttr.usrKey = segSel[ADDR_W-3];
    segAttr.noExec = segSel[ADDR_W-4];

    hashPri  = ((ADDR_W'(vsid) ^ ADDR_W'(pageIdx)) << HASH_SHIFT) & HASH_FIELD;
    hashSec  = ~hashPri & HASH_FIELD;
    tabMask  = (ADDR_W'(baseReg[MASK_BITS-1:0]) << TAB_SHIFT) | LOW_FIXED;
    groupPri = (baseReg & BASE_HI) | (hashPri & tabMask);
    groupSec = (baseReg & BASE_HI) | (hashSec & tabMask);
    cmpNext  = (ADDR_W'(vsid) << (API_W + 1)) | ADDR_W'(pageIdx >> (PIDX_W - API_W));
  end

  // Result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      primAddr   <= '0;
      secAddr    <= '0;
      cmpWord    <= '0;
      directAddr <= '0;
    end else if (ctrl.capture) begin
      primAddr   <= ctrl.genHash ? groupPri : '0;
      secAddr    <= ctrl.genHash ? groupSec : '0;
      cmpWord    <= ctrl.genHash ? cmpNext  : '0;
      directAddr <= ctrl.passDirect ? reqAddr : '0;
    end
  end

endmodule

// File: rtl/hpt_ctrl.sv
module hpt_ctrl
  import hpt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqType,
  input  logic       reqUser,
  input  segAttr_t   segAttr,
  output dpCtrl_t    ctrl,
  output logic       outValid,
  output logic       keyBit,
  output logic [1:0] faultCode
);

  logic    keyNext;
  logic    isFetch;
  logic    isWrite;
  result_e resNext;

  always_comb begin
    keyNext = (segAttr.usrKey & reqUser) | (segAttr.supKey & ~reqUser);
    isFetch = (reqType == ACC_FETCH);
    isWrite = (reqType == ACC_WRITE);
    if (!segAttr.direct) begin
      resNext = (isFetch && segAttr.noExec) ? RES_PROT : RES_HASH;
    end else if (isFetch) begin
      resNext = RES_DSERR;
    end else if (isWrite && keyNext) begin
      resNext = RES_PROT;
    end else begin
      resNext = RES_DIRECT;
    end
    ctrl.capture    = reqValid;
    ctrl.genHash    = (resNext == RES_HASH);
    ctrl.passDirect = (resNext == RES_DIRECT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      keyBit    <= 1'b0;
      faultCode <= RES_HASH;
    end else begin
      outValid <= reqValid;
      if (reqValid) begin
        keyBit    <= keyNext;
        faultCode <= resNext;
      end
    end
  end

endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
  import hpt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        segWrEn,
  input  logic [3:0]  segWrIdx,
  input  logic [31:0] segWrData,
  input  logic        baseWrEn,
  input  logic [31:0] baseWrData,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  input  logic [1:0]  reqType,
  input  logic        reqUser,
  output logic        outValid,
  output logic [31:0] primAddr,
  output logic [31:0] secAddr,
  output logic [31:0] cmpWord,
  output logic        keyBit,
  output logic [1:0]  faultCode,
  output logic [31:0] directAddr
);

  dpCtrl_t  dpCtrl;
  segAttr_t segAttr;

  hpt_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqType  (reqType),
    .reqUser  (reqUser),
    .segAttr  (segAttr),
    .ctrl     (dpCtrl),
    .outValid (outValid),
    .keyBit   (keyBit),
    .faultCode(faultCode)
  );

  hpt_dp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .segWrEn   (segWrEn),
    .segWrIdx  (segWrIdx),
    .segWrData (segWrData),
    .baseWrEn  (baseWrEn),
    .baseWrData(baseWrData),
    .reqAddr   (reqAddr),
    .ctrl      (dpCtrl),
    .segAttr   (segAttr),
    .primAddr  (primAddr),
    .secAddr   (secAddr),
    .cmpWord   (cmpWord),
    .directAddr(directAddr)
  );

endmodule

// File: rtl/hpt_addr_gen_chk.sv
module hpt_addr_gen_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] reqAddr,
  input logic [1:0]  reqType,
  input logic        outValid,
  input logic [31:0] primAddr,
  input logic [31:0] secAddr,
  input logic [31:0] cmpWord,
  input logic [1:0]  faultCode,
  input logic [31:0] directAddr
);

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid); // R2

  AST_FAULT_CLEARS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && faultCode != 2'd0) |-> (primAddr == 32'd0 && secAddr == 32'd0 && cmpWord == 32'd0)); // R8

  AST_SEC_DIFFERS_IN_HASH_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && faultCode == 2'd0) |-> (((primAddr ^ secAddr) & ~32'h01FFFFC0) == 32'd0)); // R6

  AST_CMP_LOW_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && faultCode == 2'd0) |-> (cmpWord[6] == 1'b0 && cmpWord[5:0] == $past(reqAddr[27:22]))); // R7

  AST_FETCH_NEVER_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && faultCode == 2'd1) |-> ($past(reqType) != 2'd2)); // R9

  AST_DIRECT_PASSES_EA: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && faultCode == 2'd1) |-> (directAddr == $past(reqAddr))); // R10

  AST_DIRECT_ZERO_OTHERWISE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && faultCode != 2'd1) |-> (directAddr == 32'd0)); // R10

endmodule

bind hpt_addr_gen hpt_addr_gen_chk uChk (.*);

// File: tb/hpt_addr_gen_test.sv
`timescale 1ns/1ps
module hpt_addr_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        segWrEn = 1'b0;
  logic [3:0]  segWrIdx = '0;
  logic [31:0] segWrData = '0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqType = '0;
  logic        reqUser = 1'b0;
  logic        outValid;
  logic [31:0] primAddr, secAddr, cmpWord, directAddr;
  logic        keyBit;
  logic [1:0]  faultCode;

  int testCount = 0;
  int failCount = 0;

  always #5 clk = ~clk;

  hpt_addr_gen uut (.*);

  // Reference model state
  logic [31:0] segM [16];
  logic [31:0] baseM;
  logic        expValid;
  logic [31:0] expPri, expSec, expCmp, expDir;
  logic        expKey;
  logic [1:0]  expCode;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) segM[i] = 32'd0;
      baseM = 32'd0;
      expValid = 1'b0;
    end else begin
      expValid = reqValid;
      if (reqValid) begin
        logic [31:0] s, h, h2, m, vs, pi;
        s  = segM[reqAddr >> 28];
        vs = s & 32'h00FFFFFF;
        pi = (reqAddr >> 12) & 32'hFFFF;
        expKey = (s[29] && reqUser) || (s[30] && !reqUser);
        h  = ((vs ^ pi) << 6) & 32'h01FFFFC0;
        h2 = (~h) & 32'h01FFFFC0;
        m  = ((baseM & 32'h1FF) << 16) | 32'hFFC0;
        if (!s[31]) expCode = (reqType == 2 && s[28]) ? 2'd2 : 2'd0;
        else if (reqType == 2) expCode = 2'd3;
        else if (reqType == 1 && expKey) expCode = 2'd2;
        else expCode = 2'd1;
        expPri = (expCode == 0) ? ((baseM & 32'hFFFF0000) | (h & m)) : 32'd0;
        expSec = (expCode == 0) ? ((baseM & 32'hFFFF0000) | (h2 & m)) : 32'd0;
        expCmp = (expCode == 0) ? ((vs << 7) | (pi >> 10)) : 32'd0;
        expDir = (expCode == 1) ? reqAddr : 32'd0;
      end
      if (segWrEn) segM[segWrIdx] = segWrData;   // after use: R11
      if (baseWrEn) baseM = baseWrData;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check("R2 outValid", {31'd0, outValid}, {31'd0, expValid});
      if (expValid && outValid) begin
        check("R8 R9 R10 faultCode", {30'd0, faultCode}, {30'd0, expCode});
        check("R4 keyBit", {31'd0, keyBit}, {31'd0, expKey});
        check("R5 primAddr", primAddr, expPri);
        check("R6 secAddr", secAddr, expSec);
        check("R7 cmpWord", cmpWord, expCmp);
        check("R10 directAddr", directAddr, expDir);
      end
    end
  end

  task automatic drive(input logic rv, input logic [31:0] ea, input logic [1:0] ty, input logic usr,
                       input logic sw, input logic [3:0] si, input logic [31:0] sd,
                       input logic bw, input logic [31:0] bd);
    reqValid = rv; reqAddr = ea; reqType = ty; reqUser = usr;
    segWrEn = sw; segWrIdx = si; segWrData = sd;
    baseWrEn = bw; baseWrData = bd;
    @(negedge clk);
    reqValid = 1'b0; segWrEn = 1'b0; baseWrEn = 1'b0;
  endtask

  initial begin
    #1_000_000;
    failCount++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outValid in reset", {31'd0, outValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: read at address 0 after reset
    drive(1, 32'h0, 0, 0, 0, 0, 0, 0, 0);
    check("R1 primAddr after reset", primAddr, 32'h00000000);
    check("R1 secAddr after reset", secAddr, 32'h0000FFC0);
    // R3: write segment 5 then translate through it
    drive(0, 0, 0, 0, 1, 4'd5, 32'h00ABCDEF, 1, 32'h12340155);
    drive(1, 32'h5123_4000, 0, 0, 0, 0, 0, 0, 0);
    check("R3 selected segment id", cmpWord >> 7, 32'h00ABCDEF);
    // R11: same-cycle write sees old contents
    drive(1, 32'h5000_0000, 0, 0, 1, 4'd5, 32'h00123456, 0, 0);
    check("R11 old segment used", cmpWord >> 7, 32'h00ABCDEF);
    drive(1, 32'h5000_0000, 0, 0, 0, 0, 0, 0, 0);
    check("R11 new segment after write", cmpWord >> 7, 32'h00123456);
    // R8: no-execute fetch
    drive(0, 0, 0, 0, 1, 4'd2, 32'h1000_0077, 0, 0);
    drive(1, 32'h2000_0000, 2, 0, 0, 0, 0, 0, 0);
    check("R8 nx fetch fault", {30'd0, faultCode}, 32'd2);
    // R9/R10: direct-store segment with user key
    drive(0, 0, 0, 0, 1, 4'd9, 32'hA000_0000, 0, 0);
    drive(1, 32'h9000_1234, 2, 1, 0, 0, 0, 0, 0);
    check("R9 direct-store fetch", {30'd0, faultCode}, 32'd3);
    drive(1, 32'h9000_1234, 1, 1, 0, 0, 0, 0, 0);
    check("R10 keyed write denied", {30'd0, faultCode}, 32'd2);
    drive(1, 32'h9000_1234, 0, 1, 0, 0, 0, 0, 0);
    check("R10 keyed read passes", directAddr, 32'h9000_1234);
    drive(1, 32'h9000_5678, 1, 0, 0, 0, 0, 0, 0);
    check("R10 unkeyed write passes", directAddr, 32'h9000_5678);
    // Random traffic, compared every cycle by the model
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] sd;
      sd = $urandom;
      drive(($urandom % 4) != 0, $urandom, 2'($urandom % 3), 1'($urandom),
            ($urandom % 6) == 0, 4'($urandom), sd,
            ($urandom % 20) == 0, $urandom);
    end
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule